// File: doc/BRIEF.md
# Relaxation Timer Gauge-Source Selector

This block decides which of two state-of-charge estimates a battery gauge reports. When the battery carries a heavy or changing load, the coulomb-counter estimate is used. When the load is light for a long time, the voltage-based estimate is used. The decision comes from an 8-bit saturating counter. The counter climbs one step on every slow (4 s) strobe while the signed average current stays inside a symmetric window. It falls one step on every fast (500 ms) strobe while the current is outside that window. Reaching the top of the count selects the voltage source and reaching zero selects the coulomb-counter source. Anywhere between the two ends, the last choice is kept. This gives hysteresis with a long dwell toward the voltage source and a short dwell back.

Software controls the block through a window magnitude register, a count ceiling register and two single-cycle force strobes. One strobe empties the counter and the other fills it to the ceiling. The counter value and the source flag are outputs for status readback. The estimation algorithms themselves are outside this block.

Top module: `relax_timer_sel`

## Requirements
- R1: After reset the count is 120 and the source flag is 1 (1 = voltage source, 0 = coulomb-counter source).
- R2: The current is inside the window when |avg_cur| <= thres_cfg[6:0] * 32, with avg_cur read as two's complement. The bound is inclusive and the same for both signs.
- R3: A tick_slow strobe with the current inside the window raises the count by 1 on the next clock edge. The count never goes above max_cfg.
- R4: A tick_fast strobe with the current outside the window lowers the count by 1 on the next clock edge, and the count never wraps below 0. tick_slow has no effect while the current is outside the window, and tick_fast has no effect while it is inside.
- R5: When both strobes arrive in the same cycle, exactly one step is taken. A qualifying decrement wins; otherwise an inside-window increment is taken.
- R6: One edge after the count equals max_cfg the flag becomes 1. One edge after the count equals 0 the flag becomes 0. At any other count the flag holds its value. When max_cfg is 0, the zero rule wins.
- R7: force_cc sets the count to 0 on the next edge and takes priority over force_vm and over the strobes.
- R8: force_vm, when force_cc is low, sets the count to max_cfg on the next edge.
- R9: If max_cfg is below the count, the count is clamped to max_cfg on the next edge.
- R10: While thres_cfg[7] is 1, both strobes are ignored and the count does not move. The force strobes still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| avg_cur | input | 16 | Signed average current |
| thres_cfg | input | 8 | Window magnitude in bits 6:0; bit 7 freezes stepping |
| max_cfg | input | 8 | Count ceiling |
| tick_slow | input | 1 | 4 s strobe, one cycle wide |
| tick_fast | input | 1 | 500 ms strobe, one cycle wide |
| force_cc | input | 1 | One-cycle request to empty the counter |
| force_vm | input | 1 | One-cycle request to fill the counter to the ceiling |
| count | output | 8 | Relaxation counter value |
| vm_sel | output | 1 | Source flag, 1 = voltage source |

## Verification
The count is one register away from every input. A strobe, force or ceiling change therefore shows on `count` at the first edge after it is applied. The source flag is registered from the count, so it follows one edge later. Each bench task drives its stimulus on a falling edge and removes it on the next falling edge. It then checks `count` at that point and checks `vm_sel` one falling edge later. This keeps every sample half a period away from the edge that produced the value.

// File: rtl/relax_pkg.sv
// Package: shared widths, reset value and types for the relaxation timer.
// Assumes a single clock domain; all parameters are compile-time.
package relax_pkg;
    parameter int CNT_W       = 8;    // counter / ceiling width
    parameter int CUR_W       = 16;   // signed average current width
    parameter int THR_W       = 7;    // window magnitude field width
    parameter int THR_SHIFT   = 5;    // window LSB = 2**THR_SHIFT current LSBs
    parameter int RESET_COUNT = 120;  // counter value after reset

    // Which estimate drives the reported state of charge
    typedef enum logic {
        SRC_CC = 1'b0,
        SRC_VM = 1'b1
    } soc_src_e;

    // Step request produced from strobes and the window test
    typedef struct packed {
        logic up;
        logic down;
    } step_req_t;
endpackage

// File: rtl/relax_window_cmp.sv
// Module: symmetric window test on a signed current sample.
// Assumes avg is two's complement; the most negative value is handled by
// taking the magnitude one bit wider than the input.
module relax_window_cmp #(
    parameter int CUR_W     = 16,
    parameter int THR_W     = 7,
    parameter int THR_SHIFT = 5
) (
    input  logic [CUR_W-1:0] avg,
    input  logic [THR_W-1:0] thres_mag,
    output logic             in_win
);
    localparam int MAG_W = CUR_W + 1;
    localparam int LIM_W = THR_W + THR_SHIFT;
    localparam int CMP_W = (MAG_W > LIM_W) ? MAG_W : LIM_W;

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;
    logic [CMP_W-1:0] mag_c;
    logic [CMP_W-1:0] lim_c;

    // Absolute value of the sample, widened to hold |most negative|
    always_comb begin
        ext = {avg[CUR_W-1], avg};
        mag = avg[CUR_W-1] ? (~ext + MAG_W'(1)) : ext;
    end

    // Scale the magnitude field and compare inclusively
    always_comb begin
        mag_c  = CMP_W'(mag);
        lim_c  = CMP_W'(thres_mag) << THR_SHIFT;
        in_win = (mag_c <= lim_c);
    end
endmodule

// File: rtl/relax_step_ctrl.sv
// Module: turns the two tick strobes and the window result into a single
// step request. Decrement has priority; a freeze input blocks both.
// Assumes strobes are one cycle wide.
module relax_step_ctrl
    import relax_pkg::*;
(
    input  logic      tick_slow,
    input  logic      tick_fast,
    input  logic      in_win,
    input  logic      freeze,
    output step_req_t req
);
    logic dn_ok;

    // Qualify each strobe against the window, decrement first
    always_comb begin
        dn_ok    = tick_fast && !in_win && !freeze;
        req.down = dn_ok;
        req.up   = tick_slow && in_win && !freeze && !dn_ok;
    end
endmodule

// File: rtl/relax_sat_counter.sv
// Module: saturating up/down counter with force-to-either-end and clamp to
// a ceiling that may change at any time. Priority: force_cc, force_vm,
// clamp, step. Assumes synchronous active-low reset.
module relax_sat_counter
    import relax_pkg::*;
#(
    parameter int W       = 8,
    parameter int RST_VAL = 120
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ceil_val,
    input  step_req_t    req,
    input  logic         frc_zero,
    input  logic         frc_top,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    // Next-count selection with saturation at both ends
    always_comb begin
        cnt_d = cnt_q;
        if (frc_zero)
            cnt_d = '0;
        else if (frc_top)
            cnt_d = ceil_val;
        else if (cnt_q > ceil_val)
            cnt_d = ceil_val;
        else if (req.down && (cnt_q != '0))
            cnt_d = cnt_q - W'(1);
        else if (req.up && (cnt_q < ceil_val))
            cnt_d = cnt_q + W'(1);
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/relax_src_flag.sv
// Module: hysteresis flag. Set when the count sits at the ceiling, cleared
// when it sits at zero (zero wins if both), held otherwise.
module relax_src_flag
    import relax_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ceil_val,
    output soc_src_e     src
);
    soc_src_e src_q;

    // Track end-of-range arrivals of the counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= SRC_VM;
        else if (cnt == '0)
            src_q <= SRC_CC;
        else if (cnt == ceil_val)
            src_q <= SRC_VM;
    end

    assign src = src_q;
endmodule

// File: rtl/relax_timer_sel.sv
// Top: relaxation timer that picks the state-of-charge source.
// Counts up on slow strobes while the average current is in the window,
// down on fast strobes while it is outside, and flags the source at the
// ends of the range. Assumes all inputs are synchronous to clk.
module relax_timer_sel
    import relax_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CUR_W-1:0]     avg_cur,
    input  logic [THR_W:0]       thres_cfg,
    input  logic [CNT_W-1:0]     max_cfg,
    input  logic                 tick_slow,
    input  logic                 tick_fast,
    input  logic                 force_cc,
    input  logic                 force_vm,
    output logic [CNT_W-1:0]     count,
    output logic                 vm_sel
);
    logic      in_win;
    step_req_t req;
    soc_src_e  src;

    relax_window_cmp #(
        .CUR_W     (CUR_W),
        .THR_W     (THR_W),
        .THR_SHIFT (THR_SHIFT)
    ) u_win (
        .avg       (avg_cur),
        .thres_mag (thres_cfg[THR_W-1:0]),
        .in_win    (in_win)
    );

    relax_step_ctrl u_step (
        .tick_slow (tick_slow),
        .tick_fast (tick_fast),
        .in_win    (in_win),
        .freeze    (thres_cfg[THR_W]),
        .req       (req)
    );

    relax_sat_counter #(
        .W       (CNT_W),
        .RST_VAL (RESET_COUNT)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ceil_val (max_cfg),
        .req      (req),
        .frc_zero (force_cc),
        .frc_top  (force_vm),
        .cnt      (count)
    );

    relax_src_flag #(
        .W (CNT_W)
    ) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (count),
        .ceil_val (max_cfg),
        .src      (src)
    );

    assign vm_sel = (src == SRC_VM);
endmodule

// File: rtl/relax_timer_sel_chk.sv
// Checker: temporal properties of the relaxation timer, bound to the top.
module relax_timer_sel_chk
    import relax_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] max_cfg,
    input logic             force_cc,
    input logic             force_vm,
    input logic [CNT_W-1:0] count,
    input logic             vm_sel
);
    // R3 / R9: after any edge the count is within the ceiling seen at that edge
    a_r9_within_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count <= $past(max_cfg)));

    // R7: emptying request wins
    a_r7_force_cc: assert property (@(posedge clk) disable iff (!rst_n)
        force_cc |=> (count == '0));

    // R8: fill request loads the ceiling
    a_r8_force_vm: assert property (@(posedge clk) disable iff (!rst_n)
        (force_vm && !force_cc) |=> (count == $past(max_cfg)));

    // R3 / R4: without force or clamp the count moves at most one step
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(force_cc) && !$past(force_vm)
         && ($past(count) <= $past(max_cfg)))
        |-> ((count == $past(count)) || (count == $past(count) + 8'd1)
             || (count == $past(count) - 8'd1)));

    // R6: flag only rises from a count at the ceiling
    a_r6_rise_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(vm_sel)) |-> ($past(count) == $past(max_cfg)));

    // R6: flag only falls from a zero count
    a_r6_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(vm_sel)) |-> ($past(count) == '0));
endmodule

bind relax_timer_sel relax_timer_sel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .max_cfg  (max_cfg),
    .force_cc (force_cc),
    .force_vm (force_vm),
    .count    (count),
    .vm_sel   (vm_sel)
);

// File: tb/relax_timer_sel_test.sv
module relax_timer_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] avg_cur = 16'd0;
    logic [7:0]  thres_cfg = 8'd2;
    logic [7:0]  max_cfg = 8'd120;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b0;
    logic        force_cc = 1'b0;
    logic        force_vm = 1'b0;
    logic [7:0]  count;
    logic        vm_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    relax_timer_sel uut (
        .clk(clk), .rst_n(rst_n), .avg_cur(avg_cur), .thres_cfg(thres_cfg),
        .max_cfg(max_cfg), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .force_cc(force_cc), .force_vm(force_vm), .count(count), .vm_sel(vm_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One strobe pair lasting one cycle; leaves time at the following negedge
    task automatic ticks(input bit s, input bit f);
        @(negedge clk); tick_slow = s; tick_fast = f;
        @(negedge clk); tick_slow = 1'b0; tick_fast = 1'b0;
    endtask

    task automatic forces(input bit c, input bit v);
        @(negedge clk); force_cc = c; force_vm = v;
        @(negedge clk); force_cc = 1'b0; force_vm = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 count after reset", count, 120);
        chk("R1 flag after reset", vm_sel, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_clamp();
        @(negedge clk); max_cfg = 8'd10;
        @(negedge clk);
        chk("R9 clamp to new ceiling", count, 10);
        @(negedge clk);
        chk("R6 flag at ceiling", vm_sel, 1);
    endtask

    task automatic t_window();
        avg_cur = 16'd100;           // outside limit 64
        ticks(1'b0, 1'b1);
        chk("R4 fast tick outside", count, 9);
        ticks(1'b1, 1'b0);
        chk("R4 slow tick outside ignored", count, 9);
        avg_cur = 16'd64;            // exactly on limit: inside
        ticks(1'b0, 1'b1);
        chk("R4 fast tick inside ignored", count, 9);
        ticks(1'b1, 1'b0);
        chk("R2 R3 inclusive bound step up", count, 10);
        avg_cur = -16'sd64;
        ticks(1'b1, 1'b0);
        chk("R3 saturate at ceiling", count, 10);
        avg_cur = -16'sd65;
        ticks(1'b0, 1'b1);
        chk("R2 negative just outside", count, 9);
    endtask

    task automatic t_drain();
        avg_cur = 16'h8000;          // most negative, outside
        for (int i = 0; i < 9; i++) ticks(1'b0, 1'b1);
        chk("R4 drained to zero", count, 0);
        @(negedge clk);
        chk("R6 flag cleared at zero", vm_sel, 0);
        ticks(1'b0, 1'b1);
        chk("R4 no wrap below zero", count, 0);
        avg_cur = 16'd0;
        for (int i = 0; i < 5; i++) ticks(1'b1, 1'b0);
        chk("R3 climbed to 5", count, 5);
        @(negedge clk);
        chk("R6 flag held mid range", vm_sel, 0);
    endtask

    task automatic t_force();
        forces(1'b0, 1'b1);
        chk("R8 force to ceiling", count, 10);
        @(negedge clk);
        chk("R6 flag set at ceiling", vm_sel, 1);
        forces(1'b1, 1'b0);
        chk("R7 force to zero", count, 0);
        forces(1'b0, 1'b1);
        forces(1'b1, 1'b1);
        chk("R7 zero wins over fill", count, 0);
    endtask

    task automatic t_both();
        forces(1'b0, 1'b1);
        avg_cur = 16'd100;
        ticks(1'b1, 1'b1);
        chk("R5 coincident strobes outside", count, 9);
        avg_cur = 16'd0;
        ticks(1'b1, 1'b1);
        chk("R5 coincident strobes inside", count, 10);
    endtask

    task automatic t_freeze();
        thres_cfg = 8'h82;
        avg_cur = 16'd100;
        ticks(1'b0, 1'b1);
        chk("R10 fast tick frozen", count, 10);
        forces(1'b1, 1'b0);
        chk("R10 force still acts", count, 0);
        avg_cur = 16'd0;
        ticks(1'b1, 1'b0);
        chk("R10 slow tick frozen", count, 0);
        thres_cfg = 8'd2;
    endtask

    task automatic t_zero_ceiling();
        forces(1'b0, 1'b1);
        @(negedge clk);
        chk("R6 flag set before zero ceiling", vm_sel, 1);
        max_cfg = 8'd0;
        @(negedge clk);
        chk("R9 clamp to zero ceiling", count, 0);
        @(negedge clk);
        chk("R6 zero rule wins at zero ceiling", vm_sel, 0);
    endtask

    initial begin
        t_reset();
        t_clamp();
        t_window();
        t_drain();
        t_force();
        t_both();
        t_freeze();
        t_zero_ceiling();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule